// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block keeps a small set of recent page-to-frame translations, together with each page's access rights. Any slot may hold any page. A lookup presents a virtual page number and an access kind. The page number is compared against every occupied slot in parallel. In the same cycle the block answers with one of three outcomes:

- a translated frame number,
- a protection fault, or
- a request for the page-table walker.

When the walker returns a translation, a one-cycle fill writes it into the cache. A page that is already cached is rewritten in its own slot. A page that is not cached goes into the lowest free slot. If no slot is free, the page goes into the slot used least recently. A single-cycle flush empties the whole cache, for example when the root table changes on a context switch.

Recency is kept as a per-slot age. Age 0 is the newest slot, and the oldest occupied slot of a full cache has age N-1. A permitted hit or a fill makes its slot the newest. A fault does not change any age.

Top module: `xlat_cache`

## Requirements
- R1: A lookup finds a cached page whichever slot holds it. Every occupied slot is compared with the requested page number at once, and at most one slot ever matches.
- R2: Lookup results are combinational. While `lk_vld` is high, exactly one of `lk_hit`, `lk_fault`, `walk_req` is high in that same cycle.
- R3: Each slot stores the page, the frame and three right bits: bit0 read, bit1 write, bit2 execute. The access codes on `lk_acc` are 0 read, 1 write and 2 fetch. A cached page whose right bit for the code is set gives `lk_hit`=1 and `lk_pfn` equal to the stored frame.
- R4: A cached page whose right bit is clear gives `lk_fault`=1 and `lk_pfn`=0. Access code 3 always faults on a cached page. A fault leaves the recency order unchanged.
- R5: A page that is not cached gives `walk_req`=1 and `lk_pfn`=0.
- R6: A fill is visible to lookups from the next cycle. Free slots are used before any occupied slot is replaced, so N distinct pages fit without loss.
- R7: A fill of a new page into a full cache replaces the least recently used page. A permitted hit or a fill makes its page the most recent.
- R8: A fill of a page that is already cached updates its frame and rights in place and makes it the most recent. No other page is displaced.
- R9: `flush` empties every slot in one cycle. It takes priority over a fill in the same cycle.
- R10: With `lk_vld` low, `lk_hit`, `lk_fault`, `walk_req` and `lk_pfn` are all 0.
- R11: After reset the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_vld | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 never allowed |
| lk_hit | output | 1 | Translation found and permitted |
| lk_fault | output | 1 | Page cached but access not permitted |
| walk_req | output | 1 | Page not cached; walker must fetch it |
| lk_pfn | output | PFN_W | Frame number on a hit, else 0 |
| fill_vld | input | 1 | Write a translation |
| fill_vpn | input | VPN_W | Page number of the fill |
| fill_pfn | input | PFN_W | Frame number of the fill |
| fill_perm | input | 3 | Rights of the fill: bit0 read, bit1 write, bit2 execute |
| flush | input | 1 | Empty all slots |

## Verification
The lookup outcome is due in the same cycle as the request. The bench therefore drives a lookup just after a falling edge and samples the outputs 1 ns later, before the next rising edge. Fills and flushes take effect at the next rising edge. Their results are checked only through lookups issued in the following low phase, one cycle after the stimulus. Recency is updated at the rising edge that ends a lookup. The bench's reference updates its own use order at that edge too, so replacement is checked against the order as it stands when the next fill arrives.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    // Access kinds presented on a lookup
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

    // Rights bit positions inside a stored permission field
    localparam int RIGHT_RD = 0;
    localparam int RIGHT_WR = 1;
    localparam int RIGHT_EX = 2;
    localparam int RIGHTS_W = 3;

    // Decide whether a rights field allows an access kind
    function automatic logic rights_allow(input logic [RIGHTS_W-1:0] rights, input acc_e acc);
        logic ok;
        unique case (acc)
            ACC_READ:  ok = rights[RIGHT_RD];
            ACC_WRITE: ok = rights[RIGHT_WR];
            ACC_FETCH: ok = rights[RIGHT_EX];
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/xlat_cam.sv
// Parallel tag comparator: one equality per slot, plus encoder
module xlat_cam #(
    parameter int N     = 16,
    parameter int VPN_W = 20,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0][VPN_W-1:0] tags,
    input  logic [VPN_W-1:0]        key,
    output logic [N-1:0]            match,
    output logic                    any,
    output logic [IDX_W-1:0]        idx
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    assign any = |match;

    // Lowest matching slot (at most one matches in a correct table)
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/xlat_age.sv
// Per-slot recency ages and victim choice
module xlat_age #(
    parameter int N = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [N-1:0]     valid,
    input  logic             touch_vld,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim_idx
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N - 1);

    typedef struct packed {
        logic [N-1:0][IDX_W-1:0] age;
    } age_t;

    age_t age_d, age_q;
    logic [IDX_W-1:0] ref_age;
    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] old_idx;

    // A free slot counts as older than every occupied one
    always_comb begin
        ref_age = valid[touch_idx] ? age_q.age[touch_idx] : OLDEST;
        age_d   = age_q;
        if (flush) begin
            age_d = '0;
        end else if (touch_vld) begin
            for (int i = 0; i < N; i++) begin
                if (valid[i] && (age_q.age[i] < ref_age)) begin
                    age_d.age[i] = age_q.age[i] + 1'b1;
                end
            end
            age_d.age[touch_idx] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else begin
            age_q <= age_d;
        end
    end

    // Victim: lowest free slot, otherwise the slot of greatest age
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        old_idx    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
            if (age_q.age[i] == OLDEST) begin
                old_idx = IDX_W'(i);
            end
        end
        victim_idx = free_found ? free_idx : old_idx;
    end

    AST_TOUCH_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_vld && !flush) |=> (age_q.age[$past(touch_idx)] == '0)) // R7
        else $error("touched slot is not newest");

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int N     = 16,
    parameter int VPN_W = 20,
    parameter int PFN_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lk_vld,
    input  logic [VPN_W-1:0]    lk_vpn,
    input  logic [1:0]          lk_acc,
    output logic                lk_hit,
    output logic                lk_fault,
    output logic                walk_req,
    output logic [PFN_W-1:0]    lk_pfn,
    input  logic                fill_vld,
    input  logic [VPN_W-1:0]    fill_vpn,
    input  logic [PFN_W-1:0]    fill_pfn,
    input  logic [RIGHTS_W-1:0] fill_perm,
    input  logic                flush
);

    localparam int IDX_W = $clog2(N);

    typedef struct packed {
        logic [N-1:0]                valid;
        logic [N-1:0][VPN_W-1:0]     vpn;
        logic [N-1:0][PFN_W-1:0]     pfn;
        logic [N-1:0][RIGHTS_W-1:0]  perm;
    } tab_t;

    tab_t tab_d, tab_q;

    logic [N-1:0]     lk_match, fl_match;
    logic             lk_any, fl_any;
    logic [IDX_W-1:0] lk_idx, fl_idx;
    logic [IDX_W-1:0] victim_idx;
    logic [IDX_W-1:0] fill_tgt;
    logic             allow;
    logic             touch_vld;
    logic [IDX_W-1:0] touch_idx;

    xlat_cam #(.N(N), .VPN_W(VPN_W)) u_lk_cam (
        .valid (tab_q.valid),
        .tags  (tab_q.vpn),
        .key   (lk_vpn),
        .match (lk_match),
        .any   (lk_any),
        .idx   (lk_idx)
    );

    xlat_cam #(.N(N), .VPN_W(VPN_W)) u_fl_cam (
        .valid (tab_q.valid),
        .tags  (tab_q.vpn),
        .key   (fill_vpn),
        .match (fl_match),
        .any   (fl_any),
        .idx   (fl_idx)
    );

    xlat_age #(.N(N)) u_age (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .valid      (tab_q.valid),
        .touch_vld  (touch_vld),
        .touch_idx  (touch_idx),
        .victim_idx (victim_idx)
    );

    // Lookup outcome, same cycle
    always_comb begin
        allow    = rights_allow(tab_q.perm[lk_idx], acc_e'(lk_acc));
        lk_hit   = lk_vld && lk_any && allow;
        lk_fault = lk_vld && lk_any && !allow;
        walk_req = lk_vld && !lk_any;
        lk_pfn   = lk_hit ? tab_q.pfn[lk_idx] : '0;
    end

    // Table update and recency touch
    always_comb begin
        fill_tgt  = fl_any ? fl_idx : victim_idx;
        tab_d     = tab_q;
        touch_vld = 1'b0;
        touch_idx = lk_idx;
        if (flush) begin
            tab_d.valid = '0;
        end else if (fill_vld) begin
            tab_d.valid[fill_tgt] = 1'b1;
            tab_d.vpn[fill_tgt]   = fill_vpn;
            tab_d.pfn[fill_tgt]   = fill_pfn;
            tab_d.perm[fill_tgt]  = fill_perm;
            touch_vld             = 1'b1;
            touch_idx             = fill_tgt;
        end else if (lk_hit) begin
            touch_vld = 1'b1;
            touch_idx = lk_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match)) // R1
        else $error("duplicate page in table");

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({lk_hit, lk_fault, walk_req}) == 32'(lk_vld)) // R2
        else $error("lookup outcome not unique");

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tab_q.valid == '0)) // R9
        else $error("flush left a slot occupied");

    AST_FILL_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_vld && !flush) |=> (tab_q.valid[$past(fill_tgt)] &&
                                  tab_q.vpn[$past(fill_tgt)] == $past(fill_vpn))) // R6
        else $error("fill not stored");

    AST_FAULT_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (lk_pfn == '0)) // R4
        else $error("frame leaked on fault");

endmodule

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;

    localparam int N  = 4;
    localparam int VW = 6;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_vld = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic [1:0]    lk_acc = '0;
    logic          lk_hit, lk_fault, walk_req;
    logic [PW-1:0] lk_pfn;
    logic          fill_vld = 1'b0;
    logic [VW-1:0] fill_vpn = '0;
    logic [PW-1:0] fill_pfn = '0;
    logic [2:0]    fill_perm = '0;
    logic          flush = 1'b0;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    xlat_cache #(.N(N), .VPN_W(VW), .PFN_W(PW)) dut (
        .clk(clk), .rst_n(rst_n),
        .lk_vld(lk_vld), .lk_vpn(lk_vpn), .lk_acc(lk_acc),
        .lk_hit(lk_hit), .lk_fault(lk_fault), .walk_req(walk_req), .lk_pfn(lk_pfn),
        .fill_vld(fill_vld), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_perm(fill_perm), .flush(flush)
    );

    // Reference: set of translations with last-use stamps
    bit            m_val [N];
    logic [VW-1:0] m_vpn [N];
    logic [PW-1:0] m_pfn [N];
    logic [2:0]    m_perm[N];
    int            m_stamp[N];
    int            tick = 0;

    function automatic int mfind(input logic [VW-1:0] v);
        for (int i = 0; i < N; i++) if (m_val[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic look(input logic [VW-1:0] v, input logic [1:0] a, input string req);
        int k;
        logic okp;
        logic [31:0] exp;
        @(negedge clk);
        lk_vld = 1'b1; lk_vpn = v; lk_acc = a;
        #1;
        k = mfind(v);
        okp = 1'b0;
        if (k < 0) exp = 32'({3'b001, 8'h00});
        else begin
            okp = (a == 2'd3) ? 1'b0 : m_perm[k][a];
            exp = okp ? 32'({3'b100, m_pfn[k]}) : 32'({3'b010, 8'h00});
        end
        chk(req, 32'({lk_hit, lk_fault, walk_req, lk_pfn}), exp);
        @(posedge clk);
        if (k >= 0 && okp) begin tick++; m_stamp[k] = tick; end
        #1 lk_vld = 1'b0;
    endtask

    task automatic fill(input logic [VW-1:0] v, input logic [PW-1:0] p, input logic [2:0] r);
        int k;
        @(negedge clk);
        fill_vld = 1'b1; fill_vpn = v; fill_pfn = p; fill_perm = r;
        @(posedge clk);
        k = mfind(v);
        if (k < 0) for (int i = N - 1; i >= 0; i--) if (!m_val[i]) k = i;
        if (k < 0) begin
            k = 0;
            for (int i = 1; i < N; i++) if (m_stamp[i] < m_stamp[k]) k = i;
        end
        m_val[k] = 1; m_vpn[k] = v; m_pfn[k] = p; m_perm[k] = r;
        tick++; m_stamp[k] = tick;
        #1 fill_vld = 1'b0;
    endtask

    task automatic do_flush(input bit with_fill);
        @(negedge clk);
        flush = 1'b1;
        fill_vld = with_fill; fill_vpn = 6'd9; fill_pfn = 8'h99; fill_perm = 3'b111;
        @(posedge clk);
        for (int i = 0; i < N; i++) m_val[i] = 0;
        #1 flush = 1'b0; fill_vld = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        for (int i = 0; i < N; i++) begin m_val[i] = 0; m_stamp[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11: empty after reset; R5 miss
        for (int v = 0; v < 8; v++) look(VW'(v), 2'd0, "R11 reset empty / R5 miss");

        // R3 R4: every rights pattern against every access code
        for (int p = 0; p < 8; p++) begin
            do_flush(0);
            fill(VW'(p + 16), PW'(p * 3 + 1), 3'(p));
            for (int a = 0; a < 4; a++) look(VW'(p + 16), 2'(a), "R3 R4 rights sweep");
        end

        // R1 R6: fill N pages, then sweep every page number
        do_flush(0);
        for (int i = 0; i < N; i++) fill(VW'(i * 13 + 2), PW'(8'h40 + i), 3'b111);
        for (int v = 0; v < 64; v++) look(VW'(v), 2'd0, "R1 R5 R6 full sweep");

        // R10: idle outputs with a full table
        @(negedge clk); #1;
        chk("R10 idle", 32'({lk_hit, lk_fault, walk_req, lk_pfn}), 32'h0);

        // R7: hit refreshes recency, oldest is replaced
        do_flush(0);
        for (int i = 0; i < N; i++) fill(VW'(i + 1), PW'(i + 1), 3'b001);
        look(6'd1, 2'd0, "R7 hit refresh");
        fill(6'd30, 8'h30, 3'b001);
        look(6'd2, 2'd0, "R7 oldest evicted");
        look(6'd1, 2'd0, "R7 refreshed kept");

        // R4: fault leaves recency unchanged
        do_flush(0);
        for (int i = 0; i < N; i++) fill(VW'(i + 1), PW'(i + 1), 3'b001);
        look(6'd1, 2'd1, "R4 fault");
        fill(6'd31, 8'h31, 3'b001);
        look(6'd1, 2'd0, "R4 fault did not refresh");

        // R8: refill in place, nothing displaced
        do_flush(0);
        for (int i = 0; i < N; i++) fill(VW'(i + 1), PW'(i + 1), 3'b011);
        fill(6'd2, 8'hE2, 3'b100);
        for (int i = 0; i < N; i++) look(VW'(i + 1), 2'd0, "R8 in-place refill");
        look(6'd2, 2'd2, "R8 new rights");

        // R9: flush beats a simultaneous fill
        do_flush(1);
        look(6'd9, 2'd0, "R9 flush over fill");
        for (int i = 1; i <= N; i++) look(VW'(i), 2'd0, "R9 flush empties");

        // R7 R2: long mixed traffic over 8 pages
        seed = 32'h1234_5678;
        for (int it = 0; it < 1500; it++) begin
            logic [VW-1:0] v;
            seed = seed * 32'd1664525 + 32'd1013904223;
            v = VW'(seed[18:16]);
            look(v, seed[21:20], "R7 R2 mixed traffic");
            if (mfind(v) < 0) fill(v, PW'(seed[31:24]), seed[27:25]);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule